// File: doc/BRIEF.md
# Single-Bus Multi-Cycle Sequencer

This block is a hardwired controller for a datapath in which every general register, a holding register, the program counter and memory share one data bus. Each cycle it drives a set of enables. The three-state output enables decide which source puts a value on the bus. The load enables decide which destination captures it. The controller allows at most one source on the bus in any cycle, so the sources that are not chosen keep their outputs released.

Two operations are sequenced. A fetch places the program counter on the bus, captures it in the memory address register and issues a read. The controller then keeps the bus free while the memory works through its fixed read latency, and loads the instruction register in the cycle the memory returns the word. A register move needs two bus transfers because only one value can travel on the bus per cycle. The first transfer copies the source register into the holding register. The second copies the holding register into the destination.

An operation is requested with a one-cycle start pulse that carries the operation type and two register indices. While an operation runs, a busy flag is high. When it finishes, a one-cycle done pulse is produced.

Top module: `bus_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every enable, busy and done is low.
- R2: In every cycle at most one of the bus sources (any bit of `reg_out_en`, `tmp_out`, `pc_out`) is high.
- R3: A start sampled high at a rising edge while the block is idle, with `op` = 0 (fetch), makes the next cycle assert `pc_out`, `mar_in` and `mem_rd` together for exactly one cycle.
- R4: For the MEM_LAT-1 cycles after the fetch request cycle, every bus source and load enable is low and busy is high.
- R5: `ir_ld` is high for exactly one cycle, MEM_LAT cycles after the request cycle. With the default MEM_LAT of 3, this is the fourth cycle of the fetch.
- R6: A start with `op` = 1 (move) makes the next cycle assert `reg_out_en` bit `src_idx` alone, together with `tmp_in`.
- R7: The cycle after R6 asserts `tmp_out` and `reg_in_en` bit `dst_idx` alone. This holds even when `src_idx` equals `dst_idx`.
- R8: `busy` is high from the first cycle of an operation through its last step, and low otherwise.
- R9: `done` is high for exactly one cycle, in the cycle right after the last step (`ir_ld` or the second move step). In that cycle `busy` is low.
- R10: A start pulse that arrives while busy is ignored, along with the `op` and index values it carries. The running operation completes with the indices captured when it began.
- R11: A start pulse in the cycle where `done` is high is accepted, so operations can run back to back with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request pulse |
| op | input | 1 | 0 = fetch, 1 = register move |
| src_idx | input | IW | Source register index for a move |
| dst_idx | input | IW | Destination register index for a move |
| reg_out_en | output | NREGS | Per-register bus drive enables |
| reg_in_en | output | NREGS | Per-register load enables |
| tmp_out | output | 1 | Holding register drives the bus |
| tmp_in | output | 1 | Holding register loads from the bus |
| pc_out | output | 1 | Program counter drives the bus |
| mar_in | output | 1 | Memory address register loads from the bus |
| mem_rd | output | 1 | Memory read request |
| ir_ld | output | 1 | Instruction register loads the memory word |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Take the rising edge that samples start as edge 0. The first step is then due in the cycle after edge 0. The instruction load is due MEM_LAT cycles after the request cycle. The second move step is due one cycle after the first. `done` is due one cycle after the last step. The bench keeps a queue of expected output words. At each rising edge it pops one word and, when a start is accepted against the predicted busy, pushes a new sequence. It compares every output on the falling edge that follows, so each check lands in the cycle in which the registered state has settled.

// File: rtl/ctl_bus_pkg.sv
package ctl_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREQ,
        ST_FWAIT,
        ST_FLOAD,
        ST_MV1,
        ST_MV2
    } ctl_state_e;

    typedef enum logic {
        OP_FETCH = 1'b0,
        OP_MOVE  = 1'b1
    } ctl_op_e;

endpackage

// File: rtl/ctl_wait_timer.sv
// Down-counter that marks the last memory wait cycle.
module ctl_wait_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && (count_q != '0)) begin
            count_q <= count_q - W'(1);
        end
    end

    assign last = (count_q == W'(1));
endmodule

// File: rtl/ctl_idx_decode.sv
// Index to one-hot enable, gated by a step qualifier.
module ctl_idx_decode #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [IW-1:0] idx,
    input  logic          en,
    output logic [N-1:0]  onehot
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign onehot[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
    import ctl_bus_pkg::*;
#(
    parameter int NREGS   = 4,
    parameter int MEM_LAT = 3,
    localparam int IW     = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op,
    input  logic [IW-1:0]    src_idx,
    input  logic [IW-1:0]    dst_idx,
    output logic [NREGS-1:0] reg_out_en,
    output logic [NREGS-1:0] reg_in_en,
    output logic             tmp_out,
    output logic             tmp_in,
    output logic             pc_out,
    output logic             mar_in,
    output logic             mem_rd,
    output logic             ir_ld,
    output logic             busy,
    output logic             done
);
    localparam int CW = $clog2(MEM_LAT + 1) + 1;
    localparam bit HAS_WAIT = (MEM_LAT > 1);

    typedef struct packed {
        ctl_state_e    state;
        logic [IW-1:0] src;
        logic [IW-1:0] dst;
        logic          done;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic      tmr_load, tmr_dec, tmr_last;

    ctl_wait_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (CW'(MEM_LAT - 1)),
        .dec      (tmr_dec),
        .last     (tmr_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.src   = src_idx;
                    r_d.dst   = dst_idx;
                    r_d.state = (op == OP_MOVE) ? ST_MV1 : ST_FREQ;
                end
            end
            ST_FREQ: begin
                tmr_load  = 1'b1;
                r_d.state = HAS_WAIT ? ST_FWAIT : ST_FLOAD;
            end
            ST_FWAIT: begin
                tmr_dec = 1'b1;
                if (tmr_last) r_d.state = ST_FLOAD;
            end
            ST_FLOAD: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            ST_MV1: r_d.state = ST_MV2;
            ST_MV2: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, src: '0, dst: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    ctl_idx_decode #(.N(NREGS), .IW(IW)) u_src_dec (
        .idx    (r_q.src),
        .en     (r_q.state == ST_MV1),
        .onehot (reg_out_en)
    );

    ctl_idx_decode #(.N(NREGS), .IW(IW)) u_dst_dec (
        .idx    (r_q.dst),
        .en     (r_q.state == ST_MV2),
        .onehot (reg_in_en)
    );

    assign tmp_in = (r_q.state == ST_MV1);
    assign tmp_out = (r_q.state == ST_MV2);
    assign pc_out = (r_q.state == ST_FREQ);
    assign mar_in = (r_q.state == ST_FREQ);
    assign mem_rd = (r_q.state == ST_FREQ);
    assign ir_ld = (r_q.state == ST_FLOAD);
    assign busy = (r_q.state != ST_IDLE);
    assign done = r_q.done;
endmodule

// File: rtl/bus_seq_ctrl_chk.sv
module bus_seq_ctrl_chk #(
    parameter int NREGS   = 4,
    parameter int MEM_LAT = 3,
    localparam int IW     = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op,
    input logic [IW-1:0]    src_idx,
    input logic [IW-1:0]    dst_idx,
    input logic [NREGS-1:0] reg_out_en,
    input logic [NREGS-1:0] reg_in_en,
    input logic             tmp_out,
    input logic             tmp_in,
    input logic             pc_out,
    input logic             mar_in,
    input logic             mem_rd,
    input logic             ir_ld,
    input logic             busy,
    input logic             done
);
    int lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_cnt <= 0;
        else if (mem_rd) lat_cnt <= 1;
        else if (lat_cnt != 0 && lat_cnt <= MEM_LAT) lat_cnt <= lat_cnt + 1;
        else lat_cnt <= 0;
    end

    a_r2_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_out_en, tmp_out, pc_out}) <= 1);

    a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ($countones({reg_out_en, tmp_out, pc_out, reg_in_en, tmp_in, mar_in}) == 0));

    a_r5_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ir_ld |-> (lat_cnt == MEM_LAT));

    a_r6_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        tmp_in |-> ($countones(reg_out_en) == 1));

    a_r7_second_step: assert property (@(posedge clk) disable iff (!rst_n)
        tmp_in |=> (tmp_out && $countones(reg_in_en) == 1));

    a_r8_busy_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (tmp_in || tmp_out || mem_rd || ir_ld) |-> busy);

    a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ir_ld || tmp_out) && !busy));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind bus_seq_ctrl bus_seq_ctrl_chk #(.NREGS(NREGS), .MEM_LAT(MEM_LAT)) u_chk (.*);

// File: tb/bus_seq_ctrl_test.sv
module bus_seq_ctrl_test;
    localparam int NREGS   = 4;
    localparam int MEM_LAT = 3;
    localparam int IW      = 2;

    typedef struct packed {
        logic [NREGS-1:0] ro;
        logic [NREGS-1:0] ri;
        logic to, ti, pc, mar, rd, ir, busy, done;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic op = 1'b0;
    logic [IW-1:0] src_idx = '0, dst_idx = '0;
    logic [NREGS-1:0] reg_out_en, reg_in_en;
    logic tmp_out, tmp_in, pc_out, mar_in, mem_rd, ir_ld, busy, done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "reset";
    exp_t q[$];
    exp_t cur;

    always #10 clk = ~clk;

    bus_seq_ctrl #(.NREGS(NREGS), .MEM_LAT(MEM_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_idx(src_idx), .dst_idx(dst_idx),
        .reg_out_en(reg_out_en), .reg_in_en(reg_in_en),
        .tmp_out(tmp_out), .tmp_in(tmp_in), .pc_out(pc_out),
        .mar_in(mar_in), .mem_rd(mem_rd), .ir_ld(ir_ld),
        .busy(busy), .done(done)
    );

    // Reference model: accept start only when the predicted state is idle.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            cur = '0;
        end else begin
            if (start && !cur.busy) begin
                exp_t e;
                if (op == 1'b0) begin
                    e = '0; e.pc = 1; e.mar = 1; e.rd = 1; e.busy = 1; q.push_back(e);
                    for (int i = 0; i < MEM_LAT - 1; i++) begin
                        e = '0; e.busy = 1; q.push_back(e);
                    end
                    e = '0; e.ir = 1; e.busy = 1; q.push_back(e);
                end else begin
                    e = '0; e.ro = NREGS'(1) << src_idx; e.ti = 1; e.busy = 1; q.push_back(e);
                    e = '0; e.ri = NREGS'(1) << dst_idx; e.to = 1; e.busy = 1; q.push_back(e);
                end
                e = '0; e.done = 1; q.push_back(e);
            end
            cur = (q.size() != 0) ? q.pop_front() : exp_t'('0);
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 sources", 32'($countones({reg_out_en, tmp_out, pc_out}) <= 1), 32'd1);
            chk("R3 pc_out", 32'(pc_out), 32'(cur.pc));
            chk("R3 mar_in", 32'(mar_in), 32'(cur.mar));
            chk("R3 mem_rd", 32'(mem_rd), 32'(cur.rd));
            chk("R4/R5 ir_ld", 32'(ir_ld), 32'(cur.ir));
            chk("R6 reg_out_en", 32'(reg_out_en), 32'(cur.ro));
            chk("R6 tmp_in", 32'(tmp_in), 32'(cur.ti));
            chk("R7 reg_in_en", 32'(reg_in_en), 32'(cur.ri));
            chk("R7 tmp_out", 32'(tmp_out), 32'(cur.to));
            chk("R8 busy", 32'(busy), 32'(cur.busy));
            chk("R9 done", 32'(done), 32'(cur.done));
        end
    end

    task automatic issue(input logic o, input int s, input int d);
        @(negedge clk);
        start = 1'b1; op = o; src_idx = IW'(s); dst_idx = IW'(d);
        @(negedge clk);
        start = 1'b0; op = ~o; src_idx = ~IW'(s); dst_idx = ~IW'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: outputs quiet during reset
        #5;
        chk("R1 reset outputs", 32'({reg_out_en, reg_in_en, tmp_out, tmp_in, pc_out,
            mar_in, mem_rd, ir_ld, busy, done}), 32'd0);
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'({busy, done, ir_ld, pc_out}), 32'd0);

        tag = "R3 R4 R5 fetch";
        issue(1'b0, 0, 0); idle(8);
        tag = "R6 R7 move 2->1";
        issue(1'b1, 2, 1); idle(5);
        tag = "R6 R7 move 0->3";
        issue(1'b1, 0, 3); idle(5);
        tag = "R7 move 3->3 same index";
        issue(1'b1, 3, 3); idle(5);

        // R10: second start while busy, with other op and indices
        tag = "R10 start while busy";
        issue(1'b0, 0, 0);
        issue(1'b1, 1, 2);
        idle(8);
        tag = "R10 start during move";
        issue(1'b1, 1, 2);
        @(negedge clk);
        start = 1'b0;
        issue(1'b0, 3, 0);
        idle(6);

        // R11: start in the done cycle
        tag = "R11 back to back";
        issue(1'b1, 2, 0);
        idle(1);
        issue(1'b0, 0, 0);
        idle(2);
        issue(1'b1, 1, 3);
        idle(6);

        tag = "R2 R8 R9 R10 random";
        for (int k = 0; k < 200; k++) begin
            issue(1'($urandom_range(0, 1)), int'($urandom_range(0, NREGS - 1)),
                  int'($urandom_range(0, NREGS - 1)));
            idle(int'($urandom_range(0, 5)));
        end
        idle(8);

        // R1: reset mid-operation returns everything to quiet
        tag = "R1 reset mid-op";
        issue(1'b0, 0, 0);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset", 32'({busy, pc_out, mem_rd, done}), 32'd0);
        idle(2);
        rst_n = 1'b1;
        issue(1'b1, 1, 0);
        idle(5);

        finish_run();
    end
endmodule